// File: doc/BRIEF.md
# GPIO Interrupt Aggregation Controller

This block is the interrupt front end for a bank of general-purpose input lines, and it has a small synchronous register port. Each raw line is XORed with a per-pin polarity bit. The result is the pin's data-in value, which feeds two detection paths.

The level path gates data-in with a level-enable mask. The edge path records every low-to-high transition of data-in in a sticky edge-cause register, and an edge-enable mask gates that register. A pin counts as pending when either masked path is active and the pin is configured as an input. Pending pins are ORed in groups of eight into one registered summary line per group. A downstream main interrupt controller consumes those summary lines.

Software picks rising or falling detection by setting or clearing the polarity bit. It emulates both-edge detection by flipping the polarity bit after it services each edge. To clear edge-cause bits, software writes zeros to them.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset the output value, direction, polarity, edge-cause, edge-enable and level-enable registers all read 0, every summary line is low, and `gpio_oe` is all ones.
- R2: The data-in register (word 3, read-only) reads `gpio_in ^ polarity`, where polarity is word 2. A polarity bit of 1 inverts its line.
- R3: When a pin's data-in is 1 and its level-enable bit (word 6) is 1, that pin's summary line is high on the clock edge after the line changes. The summary line falls again once data-in returns to 0.
- R4: When a pin's data-in goes from 0 to 1, its edge-cause bit (word 4) is set on the next clock edge. The bit stays set after the line returns.
- R5: With polarity 1, a falling raw line sets the edge-cause bit. With the edge-enable bit (word 5) set, the summary line is raised one cycle after the cause bit.
- R6: Writing 0 to an edge-cause bit clears it. Writing 1 to an edge-cause bit never sets it.
- R7: When a new edge and a clearing write hit the same bit in the same cycle, the bit ends up 1. Other bits cleared by the same write end up 0.
- R8: An edge-cause bit is recorded even while its edge-enable bit is 0, but it raises no summary line.
- R9: Pin p drives only summary line p/8. Pins 0–7 map to line 0, 8–15 to line 1, 16–23 to line 2 and 24–31 to line 3.
- R10: A pin whose direction bit (word 1) is 0, meaning output, contributes nothing to the summary lines. A direction bit of 1 marks an input.
- R11: A read returns the addressed register on `reg_rdata` one cycle after `reg_re`, and the value is held until the next read. Writes to data-in are ignored. `gpio_out` shows word 0 and `gpio_oe` shows the inverse of word 1.
- R12: Flipping the polarity bit while its line rests at the active level records no edge. This lets software catch the opposite transition next, which gives both-edge operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 32 | Raw input lines, already synchronized |
| gpio_out | output | 32 | Output value register |
| gpio_oe | output | 32 | Output enable per pin (1 = drive) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_re` |
| irq_group | output | 4 | Summary interrupt, one per group of eight pins |

## Verification
A stale or corrupt edge-cause bit shows up at the ports in one of two ways. Within two cycles, a summary line stays high or stays low against what the line history says it should be. Alternatively, the cause word read back one cycle after the read strobe differs from the expected value. A wrong edge-detector history, such as a missed previous value, appears as a spurious cause bit right after a polarity flip. The polarity flips in the both-edge scenario are aimed at exactly that case. A misrouted group shows as the wrong bit of `irq_group` on the cycle after the source becomes pending.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_DOUT   = 3'd0,
    REG_DIR    = 3'd1,
    REG_POL    = 3'd2,
    REG_DIN    = 3'd3,
    REG_ECAUSE = 3'd4,
    REG_EMASK  = 3'd5,
    REG_LMASK  = 3'd6
  } gpio_reg_e;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic                  reg_re,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [NUM_PINS-1:0]   reg_wdata,
  input  logic [NUM_PINS-1:0]   din_vec,
  input  logic [NUM_PINS-1:0]   ecause_vec,
  output logic [NUM_PINS-1:0]   reg_rdata,
  output logic [NUM_PINS-1:0]   cfg_dout,
  output logic [NUM_PINS-1:0]   cfg_dir,
  output logic [NUM_PINS-1:0]   cfg_pol,
  output logic [NUM_PINS-1:0]   cfg_emask,
  output logic [NUM_PINS-1:0]   cfg_lmask,
  output logic                  cause_wr
);
  gpio_reg_e sel;
  logic [NUM_PINS-1:0] rd_mux;

  assign sel      = gpio_reg_e'(reg_addr);
  assign cause_wr = reg_we && (sel == REG_ECAUSE);

  // Writable configuration words; data-in and cause are handled elsewhere.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_dout  <= '0;
      cfg_dir   <= '0;
      cfg_pol   <= '0;
      cfg_emask <= '0;
      cfg_lmask <= '0;
    end else if (reg_we) begin
      case (sel)
        REG_DOUT:  cfg_dout  <= reg_wdata;
        REG_DIR:   cfg_dir   <= reg_wdata;
        REG_POL:   cfg_pol   <= reg_wdata;
        REG_EMASK: cfg_emask <= reg_wdata;
        REG_LMASK: cfg_lmask <= reg_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_DOUT:   rd_mux = cfg_dout;
      REG_DIR:    rd_mux = cfg_dir;
      REG_POL:    rd_mux = cfg_pol;
      REG_DIN:    rd_mux = din_vec;
      REG_ECAUSE: rd_mux = ecause_vec;
      REG_EMASK:  rd_mux = cfg_emask;
      REG_LMASK:  rd_mux = cfg_lmask;
      default:    rd_mux = '0;
    endcase
  end

  // Registered read data, held between reads.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic raw,
  input  logic pol,
  input  logic dir_in,
  input  logic lmask,
  input  logic emask,
  input  logic cause_wr,
  input  logic cause_wbit,
  output logic din,
  output logic rise,
  output logic cause,
  output logic pending
);
  logic prev_q;
  logic clr;

  assign din  = raw ^ pol;
  assign rise = armed & din & ~prev_q;
  assign clr  = cause_wr & ~cause_wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cause  <= 1'b0;
    end else begin
      prev_q <= din;
      // A new edge overrides a clear in the same cycle.
      cause  <= (cause & ~clr) | rise;
    end
  end

  assign pending = dir_in & ((din & lmask) | (cause & emask));
endmodule

// File: rtl/gpio_irq_group_reduce.sv
module gpio_irq_group_reduce #(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_SIZE = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PINS-1:0]              pend_vec,
  output logic [NUM_PINS/GROUP_SIZE-1:0]   irq_group
);
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_group[g] <= 1'b0;
      else        irq_group[g] <= |pend_vec[g*GROUP_SIZE +: GROUP_SIZE];
    end
  end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_SIZE = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PINS-1:0]            gpio_in,
  output logic [NUM_PINS-1:0]            gpio_out,
  output logic [NUM_PINS-1:0]            gpio_oe,
  input  logic                           reg_we,
  input  logic                           reg_re,
  input  logic [REG_ADDR_W-1:0]          reg_addr,
  input  logic [NUM_PINS-1:0]            reg_wdata,
  output logic [NUM_PINS-1:0]            reg_rdata,
  output logic [NUM_PINS/GROUP_SIZE-1:0] irq_group
);
  logic [NUM_PINS-1:0] cfg_dout, cfg_dir, cfg_pol, cfg_emask, cfg_lmask;
  logic [NUM_PINS-1:0] din_vec, rise_vec, ecause_vec, pend_vec;
  logic cause_wr;
  logic armed;

  // Edge history is valid only from the second cycle after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .din_vec(din_vec), .ecause_vec(ecause_vec), .reg_rdata(reg_rdata),
    .cfg_dout(cfg_dout), .cfg_dir(cfg_dir), .cfg_pol(cfg_pol),
    .cfg_emask(cfg_emask), .cfg_lmask(cfg_lmask), .cause_wr(cause_wr)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk(clk), .rst_n(rst_n), .armed(armed), .raw(gpio_in[p]),
      .pol(cfg_pol[p]), .dir_in(cfg_dir[p]), .lmask(cfg_lmask[p]),
      .emask(cfg_emask[p]), .cause_wr(cause_wr), .cause_wbit(reg_wdata[p]),
      .din(din_vec[p]), .rise(rise_vec[p]), .cause(ecause_vec[p]),
      .pending(pend_vec[p])
    );
  end

  gpio_irq_group_reduce #(.NUM_PINS(NUM_PINS), .GROUP_SIZE(GROUP_SIZE)) u_red (
    .clk(clk), .rst_n(rst_n), .pend_vec(pend_vec), .irq_group(irq_group)
  );

  assign gpio_out = cfg_dout;
  assign gpio_oe  = ~cfg_dir;
endmodule

// File: rtl/gpio_irq_agg_checker.sv
module gpio_irq_agg_checker #(
  parameter int NUM_PINS   = 32,
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_re,
  input logic [NUM_PINS-1:0]   reg_rdata,
  input logic [NUM_GROUPS-1:0] irq_group,
  input logic [NUM_PINS-1:0]   cfg_dir,
  input logic [NUM_PINS-1:0]   cfg_emask,
  input logic [NUM_PINS-1:0]   cfg_lmask,
  input logic [NUM_PINS-1:0]   ecause_vec,
  input logic [NUM_PINS-1:0]   rise_vec,
  input logic [NUM_PINS-1:0]   pend_vec,
  input logic                  cause_wr
);
  // R1: nothing enabled, nothing signalled
  a_r1_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_lmask) == '0 && $past(cfg_emask) == '0) |-> irq_group == '0);

  // R3: a summary line needs a pending source one cycle earlier
  a_r3_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_group != '0) |-> ($past(pend_vec) != '0));

  // R4: cause bits only drop on a cause write
  a_r4_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cause_wr) |-> ((ecause_vec & $past(ecause_vec)) == $past(ecause_vec)));

  // R6: a write never creates a cause bit on its own
  a_r6_write_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cause_wr) |-> ((ecause_vec & ~$past(ecause_vec) & ~$past(rise_vec)) == '0));

  // R7: every detected edge lands in the cause register
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ecause_vec & $past(rise_vec)) == $past(rise_vec));

  // R10: all outputs-direction means no summary
  a_r10_dir_gates: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_dir) == '0) |-> irq_group == '0);

  // R11: read data held without a read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_re) |-> $stable(reg_rdata));
endmodule

bind gpio_irq_agg gpio_irq_agg_checker #(
  .NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_PINS/GROUP_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_re(reg_re), .reg_rdata(reg_rdata),
  .irq_group(irq_group), .cfg_dir(cfg_dir), .cfg_emask(cfg_emask),
  .cfg_lmask(cfg_lmask), .ecause_vec(ecause_vec), .rise_vec(rise_vec),
  .pend_vec(pend_vec), .cause_wr(cause_wr)
);

// File: tb/gpio_irq_agg_test.sv
module gpio_irq_agg_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_DOUT = 3'd0, A_DIR = 3'd1, A_POL = 3'd2, A_DIN = 3'd3,
                         A_ECAUSE = 3'd4, A_EMASK = 3'd5, A_LMASK = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] gpio_in = '0;
  logic [31:0] gpio_out, gpio_oe, reg_rdata, reg_wdata = '0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [3:0] irq_group;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_group(irq_group)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic quiesce();
    gpio_in = '0;
    wr(A_POL, '0); wr(A_LMASK, '0); wr(A_EMASK, '0);
    cyc(2);
    wr(A_ECAUSE, '0);
    cyc(2);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(A_DOUT, v);   chk("R1 dout", v, '0);
    rd(A_DIR, v);    chk("R1 dir", v, '0);
    rd(A_POL, v);    chk("R1 pol", v, '0);
    rd(A_ECAUSE, v); chk("R1 ecause", v, '0);
    rd(A_EMASK, v);  chk("R1 emask", v, '0);
    rd(A_LMASK, v);  chk("R1 lmask", v, '0);
    chk("R1 irq", {28'd0, irq_group}, '0);
    chk("R1 oe", gpio_oe, 32'hFFFF_FFFF);
  endtask

  task automatic test_regs();
    logic [31:0] v;
    wr(A_DOUT, 32'hA5C3_0F96);
    rd(A_DOUT, v); chk("R11 dout readback", v, 32'hA5C3_0F96);
    chk("R11 gpio_out", gpio_out, 32'hA5C3_0F96);
    wr(A_DIR, 32'hFFFF_FFFF);
    chk("R11 gpio_oe", gpio_oe, '0);
    gpio_in = 32'h1234_5678;
    wr(A_DIN, 32'hDEAD_BEEF);
    rd(A_DIN, v); chk("R11 din write ignored", v, 32'h1234_5678);
    wr(A_LMASK, 32'h0F0F_0000);
    rd(A_LMASK, v); chk("R11 lmask readback", v, 32'h0F0F_0000);
    cyc(3);
    chk("R11 rdata held", reg_rdata, 32'h0F0F_0000);
    quiesce();
  endtask

  task automatic test_polarity();
    logic [31:0] v;
    gpio_in = 32'h0000_FFFF;
    wr(A_POL, 32'h00FF_00FF);
    rd(A_DIN, v); chk("R2 din xor", v, 32'h00FF_FF00);
    quiesce();
  endtask

  task automatic test_level();
    wr(A_LMASK, 32'h0000_0200);
    gpio_in[9] = 1'b1;
    cyc(2); chk("R3 R9 level high pin9", {28'd0, irq_group}, 32'h2);
    gpio_in[9] = 1'b0;
    cyc(2); chk("R3 level drops", {28'd0, irq_group}, 32'h0);
    wr(A_POL, 32'h0000_0200);
    cyc(1); chk("R3 active-low level", {28'd0, irq_group}, 32'h2);
    quiesce();
  endtask

  task automatic test_rising();
    logic [31:0] v;
    wr(A_EMASK, 32'h0010_0000);
    gpio_in[20] = 1'b1;
    cyc(2); chk("R4 R9 rise pin20", {28'd0, irq_group}, 32'h4);
    gpio_in[20] = 1'b0;
    cyc(3); chk("R4 sticky irq", {28'd0, irq_group}, 32'h4);
    rd(A_ECAUSE, v); chk("R4 cause bit", v, 32'h0010_0000);
    wr(A_ECAUSE, ~32'h0010_0000);
    rd(A_ECAUSE, v); chk("R6 cleared", v, '0);
    cyc(1); chk("R6 irq gone", {28'd0, irq_group}, 32'h0);
    wr(A_ECAUSE, 32'hFFFF_FFFF);
    rd(A_ECAUSE, v); chk("R6 write ones no set", v, '0);
    quiesce();
  endtask

  task automatic test_falling();
    logic [31:0] v;
    gpio_in[3] = 1'b1;
    cyc(2); chk("R8 masked edge no irq", {28'd0, irq_group}, 32'h0);
    rd(A_ECAUSE, v); chk("R8 masked edge recorded", v, 32'h8);
    wr(A_POL, 32'h8);
    wr(A_ECAUSE, '0);
    wr(A_EMASK, 32'h8);
    cyc(2); chk("R5 armed idle", {28'd0, irq_group}, 32'h0);
    gpio_in[3] = 1'b0;
    cyc(1);
    rd(A_ECAUSE, v); chk("R5 falling cause", v, 32'h8);
    chk("R5 falling irq", {28'd0, irq_group}, 32'h1);
    quiesce();
  endtask

  task automatic test_set_wins();
    logic [31:0] v;
    gpio_in[13] = 1'b1;
    cyc(2);
    @(negedge clk);
    gpio_in[12] = 1'b1;
    reg_we = 1'b1; reg_addr = A_ECAUSE; reg_wdata = '0;
    @(negedge clk);
    reg_we = 1'b0;
    rd(A_ECAUSE, v); chk("R7 set beats clear", v, 32'h0000_1000);
    quiesce();
  endtask

  task automatic test_dir();
    wr(A_DIR, ~32'h0200_0000);
    wr(A_LMASK, 32'h0200_0000);
    gpio_in[25] = 1'b1;
    cyc(2); chk("R10 output pin silent", {28'd0, irq_group}, 32'h0);
    wr(A_DIR, 32'hFFFF_FFFF);
    cyc(1); chk("R10 input pin active", {28'd0, irq_group}, 32'h8);
    quiesce();
  endtask

  task automatic test_both_edge();
    logic [31:0] v;
    wr(A_EMASK, 32'h4000_0000);
    gpio_in[30] = 1'b1;
    cyc(2); chk("R12 first rise", {28'd0, irq_group}, 32'h8);
    wr(A_POL, 32'h4000_0000);
    wr(A_ECAUSE, '0);
    cyc(2); chk("R12 flip no spurious", {28'd0, irq_group}, 32'h0);
    rd(A_ECAUSE, v); chk("R12 cause after flip", v, '0);
    gpio_in[30] = 1'b0;
    cyc(2); chk("R12 fall caught", {28'd0, irq_group}, 32'h8);
    wr(A_POL, '0);
    wr(A_ECAUSE, '0);
    rd(A_ECAUSE, v); chk("R12 flip back no spurious", v, '0);
    quiesce();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    test_reset();
    test_regs();
    test_polarity();
    test_level();
    test_rising();
    test_falling();
    test_set_wins();
    test_dir();
    test_both_edge();
    summary();
  end
endmodule